// File: doc/BRIEF.md
# Lookup-Table Cubic Interpolator

This block resamples a complex baseband stream at an arbitrary fractional position between input samples. Each clock it can accept one window of four consecutive complex samples together with a 32-bit unsigned fractional interval mu, where 0 <= mu < 1. One clock it returns a single complex sample that a four-point cubic polynomial places at that fraction. The interpolated point lies between the second and third samples of the window. It is the arithmetic core of a parallel timing-recovery receiver. An upstream controller picks the sample window and the fraction; this block only does the weighting.

The four tap weights are never evaluated as polynomials in hardware. The most significant bits of mu address four read-only coefficient tables, one per tap, and the tables are filled when the design is elaborated. The in-phase and quadrature parts use the same four weights in two identical multiply-and-sum lanes. Each lane is pipelined so that a new window is accepted on every clock. The output is rounded and clamped back to the input sample width.

Top module: `cubic_lut_interp`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 5 clock cycles. Every accepted window produces exactly one result, in the order the windows were accepted, and a new window may be accepted on every clock.
- R2: While reset is active and after it is released, before any window has been accepted, `out_valid` is 0 and both `out_i` and `out_q` are 0.
- R3: The table address a is bits 31:22 of `mu`, which is floor(mu·1024). Bits 21:0 of `mu` have no effect on the result.
- R4: Tap k uses sample bits [16k+15:16k] of `in_i` and `in_q`, signed two's complement. With m = a/1024, the weights are w0 = −m³/6 + m²/2 − m/3, w1 = m³/2 − m² − m/2 + 1, w2 = −m³/2 + m²/2 + m and w3 = m³/6 − m/6. Each weight is stored as an 18-bit signed value with 16 fractional bits, rounded to nearest with ties away from zero.
- R5: Each lane's result is S = Σ wk·xk in units of 2^-16. The lane output is (S + 2^15) >> 16 using an arithmetic shift, so halves round toward plus infinity.
- R6: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: The in-phase and quadrature outputs are computed independently, each from its own four samples, with the same four weights.
- R8: When bits 31:22 of `mu` are all zero, each output equals tap 1 of its input exactly.
- R9: While `out_valid` is 0, `out_i` and `out_q` keep the value of the most recent result. Inputs presented with `in_valid` low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The window and `mu` on this cycle are accepted |
| mu | input | 32 | Unsigned fractional interval, value/2^32 |
| in_i | input | 64 | Four in-phase samples, tap k at bits [16k+15:16k] |
| in_q | input | 64 | Four quadrature samples, same layout |
| out_valid | output | 1 | A result is present on the outputs this cycle |
| out_i | output | 16 | Interpolated in-phase sample |
| out_q | output | 16 | Interpolated quadrature sample |

## Verification
The two functions that share a cycle are the acceptance of a new window at the pipeline input and the emergence of an older window's result at the output. They also share a cycle with output hold, when a gap in the input stream reaches the output. This overlap is provoked in two ways. One is long back-to-back streams of pseudo-random windows and fractions. The other is gaps in the stream during which the inputs keep changing while `in_valid` is low. A scoreboard judges it: every expected result is queued when its window is driven and popped when `out_valid` is seen. Every idle output cycle is compared against the last result. Saturating windows are placed inside the streams so that clamping and an adjacent unclamped result pass through the same stages on neighbouring cycles.

// File: rtl/cubic_interp_pkg.sv
package cubic_interp_pkg;

  // Weight of one tap, in units of 2^-frac, for table address a of an
  // aw-bit table.  Numerators are scaled by 6*2^(3*aw) so that all
  // arithmetic is exact integer before the final rounded division.
  function automatic longint tap_weight(input int tap, input int a,
                                        input int aw, input int frac);
    longint s;
    longint aa;
    longint num;
    longint den;
    begin
      s   = longint'(1) <<< aw;
      aa  = longint'(a);
      case (tap)
        0:       num = -aa*aa*aa + 3*aa*aa*s - 2*aa*s*s;
        1:       num = 3*aa*aa*aa - 6*aa*aa*s - 3*aa*s*s + 6*s*s*s;
        2:       num = -3*aa*aa*aa + 3*aa*aa*s + 6*aa*s*s;
        default: num = aa*aa*aa - aa*s*s;
      endcase
      den = 6 * (longint'(1) <<< (3*aw - frac));
      if (num >= 0) tap_weight = (num + den/2) / den;
      else          tap_weight = -((-num + den/2) / den);
    end
  endfunction

endpackage

// File: rtl/cubic_coef_rom.sv
module cubic_coef_rom #(
  parameter int TAP  = 0,
  parameter int AW   = 10,
  parameter int CW   = 18,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [AW-1:0]        addr,
  output logic signed [CW-1:0] coef
);
  import cubic_interp_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic signed [CW-1:0] tbl [DEPTH];
  logic signed [CW-1:0] coef_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam longint VAL = tap_weight(TAP, g, AW, FRAC);
    assign tbl[g] = CW'(VAL);
  end

  always_comb begin
    coef_d = coef;
    if (ld) coef_d = tbl[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef <= '0;
    else        coef <= coef_d;
  end
endmodule

// File: rtl/cubic_mac_lane.sv
module cubic_mac_lane #(
  parameter int SW   = 16,
  parameter int CW   = 18,
  parameter int FRAC = 16,
  parameter int TAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_smp,
  input  logic                 ld_prod,
  input  logic                 ld_pair,
  input  logic                 ld_sum,
  input  logic                 ld_out,
  input  logic [TAPS*SW-1:0]   smp_in,
  input  logic [TAPS*CW-1:0]   coef_in,
  output logic signed [SW-1:0] y
);
  localparam int PW = SW + CW;
  localparam int HW = PW + 1;
  localparam int TW = PW + 2;
  localparam int RW = TW + 1;
  localparam logic signed [RW-1:0] RND  = RW'(1) <<< (FRAC - 1);
  localparam logic signed [RW-1:0] YMAX = RW'((1 << (SW - 1)) - 1);
  localparam logic signed [RW-1:0] YMIN = -RW'(1 << (SW - 1));

  logic signed [SW-1:0] smp_q  [TAPS];
  logic signed [SW-1:0] smp_d  [TAPS];
  logic signed [PW-1:0] prod_q [TAPS];
  logic signed [PW-1:0] prod_d [TAPS];
  logic signed [HW-1:0] pair_q [2];
  logic signed [HW-1:0] pair_d [2];
  logic signed [TW-1:0] sum_q, sum_d;
  logic signed [RW-1:0] rnd_v, shf_v;
  logic signed [SW-1:0] y_d;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [CW-1:0] c_k;
    assign c_k = coef_in[k*CW +: CW];

    always_comb begin
      smp_d[k] = smp_q[k];
      if (ld_smp) smp_d[k] = smp_in[k*SW +: SW];
      prod_d[k] = prod_q[k];
      if (ld_prod) prod_d[k] = PW'(smp_q[k]) * PW'(c_k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q[k]  <= '0;
        prod_q[k] <= '0;
      end else begin
        smp_q[k]  <= smp_d[k];
        prod_q[k] <= prod_d[k];
      end
    end
  end

  always_comb begin
    pair_d[0] = pair_q[0];
    pair_d[1] = pair_q[1];
    if (ld_pair) begin
      pair_d[0] = HW'(prod_q[0]) + HW'(prod_q[1]);
      pair_d[1] = HW'(prod_q[2]) + HW'(prod_q[3]);
    end
    sum_d = sum_q;
    if (ld_sum) sum_d = TW'(pair_q[0]) + TW'(pair_q[1]);
    rnd_v = RW'(sum_q) + RND;
    shf_v = rnd_v >>> FRAC;
    y_d = y;
    if (ld_out) begin
      if (shf_v > YMAX)      y_d = YMAX[SW-1:0];
      else if (shf_v < YMIN) y_d = YMIN[SW-1:0];
      else                   y_d = shf_v[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q[0] <= '0;
      pair_q[1] <= '0;
      sum_q     <= '0;
      y         <= '0;
    end else begin
      pair_q[0] <= pair_d[0];
      pair_q[1] <= pair_d[1];
      sum_q     <= sum_d;
      y         <= y_d;
    end
  end
endmodule

// File: rtl/cubic_lut_interp.sv
module cubic_lut_interp #(
  parameter int SW   = 16,
  parameter int CW   = 18,
  parameter int FRAC = 16,
  parameter int MUW  = 32,
  parameter int AW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MUW-1:0]    mu,
  input  logic [4*SW-1:0]   in_i,
  input  logic [4*SW-1:0]   in_q,
  output logic              out_valid,
  output logic [SW-1:0]     out_i,
  output logic [SW-1:0]     out_q
);
  localparam int TAPS  = 4;
  localparam int DEPTH = 5;

  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  logic [DEPTH:1]     vld_q, vld_d;
  logic [AW-1:0]      addr;
  logic [TAPS*CW-1:0] coef_bus;
  logic [SW-1:0]      lane_y [2];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign addr = mu[MUW-1 -: AW];

  always_comb vld_d = {vld_q[DEPTH-1:1], in_valid};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= '0;
    else             vld_q <= vld_d;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_rom
    cubic_coef_rom #(.TAP(k), .AW(AW), .CW(CW), .FRAC(FRAC)) u_rom (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ld    (in_valid),
      .addr  (addr),
      .coef  (coef_bus[k*CW +: CW])
    );
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    cubic_mac_lane #(.SW(SW), .CW(CW), .FRAC(FRAC), .TAPS(TAPS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ld_smp  (in_valid),
      .ld_prod (vld_q[1]),
      .ld_pair (vld_q[2]),
      .ld_sum  (vld_q[3]),
      .ld_out  (vld_q[4]),
      .smp_in  ((l == 0) ? in_i : in_q),
      .coef_in (coef_bus),
      .y       (lane_y[l])
    );
  end

  assign out_valid = vld_q[DEPTH];
  assign out_i     = lane_y[0];
  assign out_q     = lane_y[1];
endmodule

// File: rtl/cubic_lut_interp_chk.sv
module cubic_lut_interp_chk #(
  parameter int SW  = 16,
  parameter int MUW = 32,
  parameter int AW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [MUW-1:0]  mu,
  input  logic [4*SW-1:0] in_i,
  input  logic [4*SW-1:0] in_q,
  input  logic            out_valid,
  input  logic [SW-1:0]   out_i,
  input  logic [SW-1:0]   out_q
);
  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 7) age <= age + 3'd1;
  end

  // R2
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_i == '0 && out_q == '0));

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 5) |-> (out_valid == $past(in_valid, 5)));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 1 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));

  // R8
  zero_mu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 5 && $past(in_valid && mu[MUW-1 -: AW] == '0, 5)) |->
      (out_i == $past(in_i[SW +: SW], 5) && out_q == $past(in_q[SW +: SW], 5)));
endmodule

bind cubic_lut_interp cubic_lut_interp_chk #(.SW(SW), .MUW(MUW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .mu        (mu),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/cubic_lut_interp_tb.sv
module cubic_lut_interp_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] mu = '0;
  logic [63:0] in_i = '0;
  logic [63:0] in_q = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit have_last = 1'b0;
  logic [15:0] last_i = '0, last_q = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  logic [15:0] exp_i[$];
  logic [15:0] exp_q[$];
  string       exp_tag[$];

  cubic_lut_interp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mu(mu),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tap weight from the R4 polynomials, exact sixths, ties away from zero
  function automatic longint ref_w(input int k, input int a);
    longint m, n, d;
    m = a;
    case (k)
      0: n = -m*m*m + 3*m*m*1024 - 2*m*1048576;
      1: n = 3*m*m*m - 6*m*m*1024 - 3*m*1048576 + 6*longint'(1073741824);
      2: n = -3*m*m*m + 3*m*m*1024 + 6*m*1048576;
      default: n = m*m*m - m*1048576;
    endcase
    d = 6 * 16384;
    return (n >= 0) ? (n + d/2) / d : -((-n + d/2) / d);
  endfunction

  function automatic logic [15:0] ref_y(input logic [31:0] m, input logic [63:0] s);
    longint acc, y;
    int a;
    a = int'(m[31:22]);
    acc = 0;
    for (int k = 0; k < 4; k++)
      acc += ref_w(k, a) * longint'($signed(s[k*16 +: 16]));
    y = (acc + 32768) >>> 16;          // R5
    if (y > 32767)  y = 32767;         // R6
    if (y < -32768) y = -32768;
    return y[15:0];
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] v;
    v = x ^ (x << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(expv));
    end
  endtask

  task automatic send(input logic [31:0] m, input logic [63:0] si,
                      input logic [63:0] sq, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mu = m; in_i = si; in_q = sq;
    exp_i.push_back(ref_y(m, si));
    exp_q.push_back(ref_y(m, sq));
    exp_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      lfsr = nxt(lfsr);
      in_valid = 1'b0;                 // R9: junk while not valid
      mu = lfsr; in_i = {lfsr, ~lfsr}; in_q = {~lfsr, lfsr};
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_i.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 actual=unexpected_result expected=none");
        end else begin
          string t;
          logic [15:0] ei, eq;
          t = exp_tag.pop_front(); ei = exp_i.pop_front(); eq = exp_q.pop_front();
          check({t, " I"}, out_i, ei);
          check({t, " Q"}, out_q, eq);
        end
        last_i = out_i; last_q = out_q; have_last = 1'b1;
      end else if (have_last) begin
        check("R9 hold I", out_i, last_i);
        check("R9 hold Q", out_q, last_q);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset valid", {15'd0, out_valid}, 16'd0);
    check("R2 reset I", out_i, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 post-reset valid", {15'd0, out_valid}, 16'd0);
    check("R2 post-reset Q", out_q, 16'd0);

    // R1: single window, output 5 cycles later
    send(32'h4000_0000, 64'h0400_0300_0200_0100, 64'hFF00_FE00_FD00_FC00, "R1 single");
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 latency", {15'd0, out_valid}, (c == 5) ? 16'd1 : 16'd0);
    end
    idle(3);

    // R8: mu top bits zero, low bits set
    send(32'h003F_FFFF, 64'h1111_8001_2345_7777, 64'h0001_7FFF_DEAD_0002, "R8 mu0");
    send(32'h0000_0000, 64'h0000_C000_0000_0000, 64'h0000_0000_4000_0000, "R8 mu0b");
    // R3: same address, different low bits
    send(32'h9A40_0000, 64'h0123_0456_F789_0ABC, 64'h7000_9000_7000_9000, "R3 low0");
    send(32'h9A7F_FFFF, 64'h0123_0456_F789_0ABC, 64'h7000_9000_7000_9000, "R3 low1");
    // R4: top of table
    send(32'hFFFF_FFFF, 64'h1000_2000_3000_4000, 64'hF000_E000_D000_C000, "R4 top");
    // R6: positive and negative clamp around an ordinary window
    send(32'h8000_0000, 64'h8000_7FFF_7FFF_8000, 64'h7FFF_8000_8000_7FFF, "R6 sat");
    send(32'h8000_0000, 64'h0010_0020_0030_0040, 64'hFFF0_FFE0_FFD0_FFC0, "R7 mid");
    send(32'h2000_0000, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, "R6 flat");
    idle(7);

    // R4 R5 R7: pseudo-random streams with gaps
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r1, r2, r3, r4, r5;
      lfsr = nxt(lfsr); r1 = lfsr;
      lfsr = nxt(lfsr); r2 = lfsr;
      lfsr = nxt(lfsr); r3 = lfsr;
      lfsr = nxt(lfsr); r4 = lfsr;
      lfsr = nxt(lfsr); r5 = lfsr;
      send(r1, {r2, r3}, {r4, r5}, "R4/R5 stream");
      if (r5[4:0] == 5'd0) idle(int'(r4[2:0]) + 1);
    end
    idle(10);

    checks++;
    if (exp_i.size() != 0) begin
      failures++;
      $display("FAIL R1 actual=%0d pending expected=0", exp_i.size());
    end
    done = 1'b1;
    summary();
  end
endmodule